// File: doc/BRIEF.md
# Keyboard Code Serializer with Auto-Repeat

This block takes the eight-bit code a key encoder presents on parallel lines, qualified by an active-low strobe, and sends it toward a terminal controller as an eleven-bit asynchronous frame. The frame goes out on a complementary pair of outputs. A second complementary pair reports whether the terminal is operational. The terminal counts as operational only while both horizontal sync and supply power are present.

Strobe and repeat inputs are asynchronous to the block clock and pass through a synchronizer chain. The code is captured when the synchronized strobe falls. The frame starts as soon as the serializer is free. A strobe that arrives while a frame is on the line is remembered, and its code is sent once that frame is complete.

If the active-low repeat key is already held when the strobe is recognised, the block arms auto-repeat. It then resends the captured code once per repeat interval for as long as the key stays held. `REPEAT_TICKS` sets the interval; 100 ms gives the nominal 10 Hz. `CLK_DIV` sets the bit period in clock cycles.

Top module: `key_serial_tx`

## Requirements
- R1: While reset is applied, and after it, until stimulus arrives: `ser_p`=1, `ser_n`=0 (idle line), `rdy_p`=0 and `rdy_n`=1 (not-ready).
- R2: `ser_n` is always the complement of `ser_p`, and `rdy_n` is always the complement of `rdy_p`.
- R3: Suppose `key_stb_n` is first sampled low at a clock edge after having been high, and the serializer is idle. Then `key_code` is captured, and the start bit of its frame appears on `ser_p` after the edge that is `SYNC_STAGES`+1 edges later.
- R4: A frame is 11 bits, each held for exactly `CLK_DIV` cycles. The order is: start bit 0, the eight data bits least significant first, an odd parity bit (data ones plus parity is odd), then stop bit 1. The line is 1 between frames, and there is at least one idle cycle between frames.
- R5: A strobe recognised while a frame is being sent does not disturb that frame. The most recently captured code is sent once, in the frame that follows the current one. Earlier codes captured during the same frame are dropped.
- R6: If `rep_n` is low when a strobe is recognised, auto-repeat is armed. The code is then queued for retransmission every `REPEAT_TICKS` cycles, counted from the recognition of the strobe, while `rep_n` stays low.
- R7: If `rep_n` goes low only after the strobe was recognised, no retransmission occurs.
- R8: Once the synchronized `rep_n` returns high, auto-repeat is disarmed and no further retransmission is queued. A frame already on the line completes unchanged.
- R9: `rdy_p` equals `hsync_ok` AND `power_ok` as sampled at the previous clock edge.
- R10: A new strobe recognised while auto-repeat is running replaces the repeated code. It also restarts the repeat interval from that strobe, and re-arms or disarms auto-repeat according to `rep_n` at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_code | input | DATA_W | Parallel key code, active high |
| key_stb_n | input | 1 | Active-low strobe marking a new stable code |
| rep_n | input | 1 | Active-low repeat key |
| hsync_ok | input | 1 | High while horizontal sync is present |
| power_ok | input | 1 | High while supply power is good |
| ser_p | output | 1 | Serial frame, true polarity |
| ser_n | output | 1 | Serial frame, inverted polarity |
| rdy_p | output | 1 | Terminal ready, true polarity |
| rdy_n | output | 1 | Terminal ready, inverted polarity |

## Verification
The assertions assume the following about the inputs:
- The strobe stays low, and then high, for longer than the synchronizer depth.
- `key_code` holds its value across the cycle in which the falling strobe is recognised.
- `rep_n` does not chatter faster than the clock.

The stimulus holds the strobe low for eight cycles with a steady code, and changes every input only at falling clock edges. Frames, parity patterns, mid-frame strobes, repeat key held before and after the strobe, and release timing are each exercised, with the ready inputs toggled independently of the serial traffic.

// File: rtl/kst_pkg.sv
package kst_pkg;
    // Serializer activity
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_e;

    // Framing overhead around the data bits: start, parity, stop
    localparam int FRAME_EXTRA = 3;
endpackage

// File: rtl/kst_sync.sv
module kst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/kst_shifter.sv
module kst_shifter
    import kst_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              line
);
    localparam int NB = DATA_W + FRAME_EXTRA;
    localparam int BW = $clog2(NB);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(NB - 1);
    localparam logic [DW-1:0] LAST_DIV = DW'(CLK_DIV - 1);

    typedef struct packed {
        tx_state_e       state;
        logic [NB-1:0]   sh;
        logic [BW-1:0]   bit_idx;
        logic [DW-1:0]   div;
        logic            line;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            TX_IDLE: begin
                r_d.line = 1'b1;
                if (load) begin
                    r_d.state   = TX_BUSY;
                    // stop, odd parity, data (LSB leaves first), start
                    r_d.sh      = {1'b1, ~^data, data, 1'b0};
                    r_d.bit_idx = '0;
                    r_d.div     = '0;
                    r_d.line    = 1'b0;
                end
            end
            default: begin
                if (r_q.div == LAST_DIV) begin
                    r_d.div = '0;
                    if (r_q.bit_idx == LAST_BIT) begin
                        r_d.state = TX_IDLE;
                        r_d.line  = 1'b1;
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.sh      = r_q.sh >> 1;
                        r_d.line    = r_q.sh[1];
                    end
                end else begin
                    r_d.div = r_q.div + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= TX_IDLE;
            r_q.sh      <= '1;
            r_q.bit_idx <= '0;
            r_q.div     <= '0;
            r_q.line    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state == TX_BUSY);
    assign line = r_q.line;

    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.bit_idx <= LAST_BIT));
    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line);
    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.div != '0) |-> $stable(line));
    // R4
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(line));
endmodule

// File: rtl/kst_repeat.sv
module kst_repeat #(
    parameter int TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic new_code,
    input  logic rep_act,
    output logic fire
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS - 1);

    typedef struct packed {
        logic          arm;
        logic [TW-1:0] tmr;
    } rpt_t;

    rpt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (new_code) begin
            r_d.arm = rep_act;
            r_d.tmr = '0;
        end else if (!r_q.arm || !rep_act) begin
            r_d.arm = 1'b0;
            r_d.tmr = '0;
        end else if (r_q.tmr == LAST_TICK) begin
            r_d.tmr = '0;
        end else begin
            r_d.tmr = r_q.tmr + 1'b1;
        end
    end

    assign fire = !new_code && r_q.arm && rep_act && (r_q.tmr == LAST_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.arm <= 1'b0;
            r_q.tmr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R7
    arm_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.arm) |-> $past(new_code && rep_act));
    // R8
    disarm_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.arm) |-> $past(!rep_act));
    // R6
    interval_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (r_q.tmr == '0));
endmodule

// File: rtl/key_serial_tx.sv
module key_serial_tx #(
    parameter int DATA_W       = 8,
    parameter int CLK_DIV      = 16,
    parameter int REPEAT_TICKS = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] key_code,
    input  logic              key_stb_n,
    input  logic              rep_n,
    input  logic              hsync_ok,
    input  logic              power_ok,
    output logic              ser_p,
    output logic              ser_n,
    output logic              rdy_p,
    output logic              rdy_n
);
    typedef struct packed {
        logic              stb_prev;
        logic [DATA_W-1:0] code;
        logic              pend;
        logic              rdy;
    } top_t;

    top_t r_q, r_d;

    logic s_stb_n, s_rep_n;
    logic fall, fire, load, busy, line;

    kst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(key_stb_n), .q(s_stb_n)
    );

    kst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rep_sync (
        .clk(clk), .rst_n(rst_n), .d(rep_n), .q(s_rep_n)
    );

    assign fall = r_q.stb_prev && !s_stb_n;
    assign load = r_q.pend && !busy;

    kst_repeat #(.TICKS(REPEAT_TICKS)) u_repeat (
        .clk(clk), .rst_n(rst_n), .new_code(fall), .rep_act(!s_rep_n), .fire(fire)
    );

    kst_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .data(r_q.code),
        .busy(busy), .line(line)
    );

    always_comb begin
        r_d          = r_q;
        r_d.stb_prev = s_stb_n;
        if (fall) r_d.code = key_code;
        r_d.pend     = fall || fire || (r_q.pend && !load);
        r_d.rdy      = hsync_ok && power_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stb_prev <= 1'b1;
            r_q.code     <= '0;
            r_q.pend     <= 1'b0;
            r_q.rdy      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ser_p = line;
    assign ser_n = ~line;
    assign rdy_p = r_q.rdy;
    assign rdy_n = ~r_q.rdy;

    // R9
    ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_p |-> $past(hsync_ok && power_ok));
    // R5
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && busy) |=> r_q.pend);
    // R3
    start_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.pend));
endmodule

// File: tb/sim_key_serial_tx.sv
module sim_key_serial_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CD = 4;
    localparam int RT = 150;
    localparam int SS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] key_code = '0;
    logic          key_stb_n = 1'b1;
    logic          rep_n = 1'b1;
    logic          hsync_ok = 1'b1;
    logic          power_ok = 1'b1;
    logic          ser_p, ser_n, rdy_p, rdy_n;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    key_serial_tx #(.DATA_W(DW), .CLK_DIV(CD), .REPEAT_TICKS(RT), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_stb_n(key_stb_n),
        .rep_n(rep_n), .hsync_ok(hsync_ok), .power_ok(power_ok),
        .ser_p(ser_p), .ser_n(ser_n), .rdy_p(rdy_p), .rdy_n(rdy_n)
    );

    // Behavioural reference: input histories, a queue of line levels, counters
    bit        stb_hist[$];
    bit        rep_hist[$];
    bit        line_plan[$];
    bit        m_pend;
    bit        m_arm;
    int        m_tick;
    bit [DW-1:0] m_code;
    bit        m_rdy;

    function automatic void model_reset();
        stb_hist = {};
        rep_hist = {};
        line_plan = {};
        for (int i = 0; i <= SS; i++) begin
            stb_hist.push_back(1'b1);
            rep_hist.push_back(1'b1);
        end
        m_pend = 0; m_arm = 0; m_tick = 0; m_code = '0; m_rdy = 0;
    endfunction

    function automatic void plan_frame(bit [DW-1:0] c);
        bit seq[$];
        int ones = 0;
        seq.push_back(1'b0);
        for (int i = 0; i < DW; i++) begin
            seq.push_back(c[i]);
            ones += c[i];
        end
        seq.push_back((ones % 2) == 0);
        seq.push_back(1'b1);
        foreach (seq[k])
            for (int j = 0; j < CD; j++) line_plan.push_back(seq[k]);
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit was_busy, stb_fall, rep_on, do_load, do_fire;
            int sz;
            stb_hist.push_back(key_stb_n);
            rep_hist.push_back(rep_n);
            sz = stb_hist.size();
            stb_fall = stb_hist[sz-SS-2] && !stb_hist[sz-SS-1];
            rep_on   = !rep_hist[sz-SS-1];
            was_busy = line_plan.size() != 0;
            if (was_busy) void'(line_plan.pop_front());
            do_load = m_pend && !was_busy;
            if (do_load) plan_frame(m_code);
            do_fire = !stb_fall && m_arm && rep_on && (m_tick == RT-1);
            if (stb_fall) begin
                m_arm = rep_on; m_tick = 0;
            end else if (!m_arm || !rep_on) begin
                m_arm = 0; m_tick = 0;
            end else if (m_tick == RT-1) begin
                m_tick = 0;
            end else begin
                m_tick++;
            end
            m_pend = stb_fall || do_fire || (m_pend && !do_load);
            if (stb_fall) m_code = key_code;
            m_rdy = hsync_ok && power_ok;
            while (stb_hist.size() > SS + 4) begin
                void'(stb_hist.pop_front());
                void'(rep_hist.pop_front());
            end
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit exp_line;
            exp_line = (line_plan.size() != 0) ? line_plan[0] : 1'b1;
            n_checks++;
            if (ser_p !== exp_line) begin
                n_fail++;
                $display("FAIL %s ser_p at %0t: actual %b expected %b", tag, $time, ser_p, exp_line);
            end
            n_checks++;
            if (ser_n !== ~ser_p) begin
                n_fail++;
                $display("FAIL R2 ser_n at %0t: actual %b expected %b", $time, ser_n, ~ser_p);
            end
            n_checks++;
            if (rdy_p !== m_rdy) begin
                n_fail++;
                $display("FAIL R9 rdy_p at %0t: actual %b expected %b", $time, rdy_p, m_rdy);
            end
            n_checks++;
            if (rdy_n !== ~rdy_p) begin
                n_fail++;
                $display("FAIL R2 rdy_n at %0t: actual %b expected %b", $time, rdy_n, ~rdy_p);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(bit [DW-1:0] c);
        @(negedge clk);
        key_code  = c;
        key_stb_n = 1'b0;
        idle(8);
        key_stb_n = 1'b1;
    endtask

    initial begin
        idle(3);
        // R1: reset state at the ports
        n_checks++;
        if ({ser_p, ser_n, rdy_p, rdy_n} !== 4'b1001) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %b expected 1001", {ser_p, ser_n, rdy_p, rdy_n});
        end
        @(negedge clk) rst_n = 1'b1;
        idle(5);

        tag = "R3 R4 single";
        press(8'hA5); idle(60);
        tag = "R4 parity";
        press(8'h00); idle(55);
        press(8'hFF); idle(55);
        press(8'h01); idle(55);

        tag = "R5 mid-frame";
        press(8'h3C); idle(10);
        press(8'h11); idle(4);
        press(8'h22); idle(120);

        tag = "R6 R8 repeat";
        @(negedge clk) rep_n = 1'b0;
        idle(4);
        press(8'h5A); idle(400);
        rep_n = 1'b1; idle(250);

        tag = "R7 late repeat";
        press(8'h77); idle(3);
        rep_n = 1'b0; idle(400);
        rep_n = 1'b1; idle(60);

        tag = "R10 new strobe";
        rep_n = 1'b0; idle(4);
        press(8'h12); idle(200);
        press(8'h34); idle(330);
        rep_n = 1'b1; idle(100);

        tag = "R9 ready";
        hsync_ok = 1'b0; idle(3);
        power_ok = 1'b0; idle(3);
        hsync_ok = 1'b1; idle(3);
        power_ok = 1'b1; idle(3);
        press(8'hC3);
        hsync_ok = 1'b0; idle(20);
        hsync_ok = 1'b1; idle(50);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule